// File: doc/BRIEF.md
# Timer Channel Input Conditioner with Edge Flag

This block is the input side of one timer channel. An asynchronous pin first passes through a synchronizer and then through a glitch filter. The filter rejects any pulse shorter than a programmable number of filter-clock ticks. The filter is clocked either on every cycle of the main clock or only on cycles where a prescaler strobe is high.

A small qualifier watches the filtered level for edges. Depending on configuration it accepts:

- only rising edges,
- only falling edges,
- both edges, or
- nothing at all, when the channel is a plain GPIO input that must not raise flags.

Each accepted edge latches the value of an external 16-bit time base into a capture register and sets the channel flag. An edge that arrives while the flag is still set also marks an overrun. Software clears the flag and the overrun by writing one to them. A DMA acknowledge also clears the flag. A global enable gates the request, and a select bit steers it to either an interrupt line or a DMA request line.

Top module: `tmr_in_filter`

## Requirements
- R1: After a synchronous reset, `level_o`, `flag_o`, `ovr_o`, `irq_o`, `dma_req_o` and `capture_o` are all zero.
- R2: With `cfg_width` = 0 the filter is bypassed. A pin change appears on `level_o` after exactly three rising clock edges: two synchronizer stages plus the filter register.
- R3: With `cfg_width` = N, where N is 1 to 4, and `cfg_fast_clk` = 1, a pin pulse must last at least 2^N clock cycles to reach `level_o`. A pulse of 2^N−1 cycles is rejected. Codes 5 to 15 behave like code 4.
- R4: With `cfg_fast_clk` = 0, the filter counts only cycles where `tick_i` is high. When `tick_i` is low and the filter is not bypassed, `level_o` holds its value.
- R5: With `cfg_both_edges` = 0, only one edge qualifies. `cfg_rise_pol` = 1 selects the 0→1 transition of `level_o`, and 0 selects the 1→0 transition.
- R6: With `cfg_both_edges` = 1 in input mode (`cfg_gpio_mode` = 0), every transition of `level_o` qualifies.
- R7: With `cfg_gpio_mode` = 1 and `cfg_both_edges` = 1, no edge qualifies, so the flag and the capture register are left untouched. With `cfg_gpio_mode` = 1 and `cfg_both_edges` = 0, qualification is as in R5.
- R8: On every qualifying edge, `capture_o` takes the value of `timebase_i`. At all other times `capture_o` holds its value.
- R9: A qualifying edge that arrives while `flag_o` is already 1, and is not being cleared in the same cycle, sets `ovr_o`. `ovr_o` never rises while `flag_o` is 0.
- R10: A pulse on `clr_flag_i` or `dma_ack_i` clears `flag_o`. A pulse on `clr_ovr_i` clears `ovr_o`. A new qualifying edge in the same cycle wins over the clear.
- R11: `irq_o` = `cfg_flag_en` & !`cfg_dma_sel` & (flag | overrun). `dma_req_o` = `cfg_flag_en` & `cfg_dma_sel` & (flag | overrun). The two are never high together, and both are 0 while the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous channel pin |
| tick_i | input | 1 | Prescaled filter-clock strobe |
| cfg_width | input | 4 | Filter width code (0 = bypass) |
| cfg_fast_clk | input | 1 | 1: filter counts every clock; 0: counts only on `tick_i` |
| cfg_both_edges | input | 1 | Both-edge select; in GPIO mode, 1 suppresses flagging |
| cfg_rise_pol | input | 1 | Single-edge polarity: 1 rising, 0 falling |
| cfg_gpio_mode | input | 1 | GPIO-input mode |
| cfg_flag_en | input | 1 | Request enable |
| cfg_dma_sel | input | 1 | 1: DMA request; 0: interrupt |
| timebase_i | input | 16 | Selected time-base value |
| clr_flag_i | input | 1 | Write-one-to-clear strobe for the flag |
| clr_ovr_i | input | 1 | Write-one-to-clear strobe for the overrun |
| dma_ack_i | input | 1 | DMA acknowledge; clears the flag |
| level_o | output | 1 | Filtered pin level |
| capture_o | output | 16 | Captured time-base value |
| flag_o | output | 1 | Channel flag |
| ovr_o | output | 1 | Overrun |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
The assertions check, on every cycle:

- The filtered level only changes to the value seen at the synchronizer output, and holds while a prescaled filter sees no strobe.
- The capture register moves only on a qualified edge.
- Suppressing GPIO mode never yields an edge.
- Overrun never rises without a standing flag.
- The clears take effect.
- The interrupt and DMA lines are exclusive.

Only the bench scenarios can show the following:

- The exact pulse-width threshold for each code, including the saturation of codes above 4.
- The bypass latency.
- Which edge polarity raises the flag.
- That the captured value is the time base present at the edge.

// File: rtl/tif_pkg.sv
package tif_pkg;

  // Channel input configuration, collected from the top-level pins.
  typedef struct packed {
    logic [3:0] width_code;
    logic       fast_clk;
    logic       both_edges;
    logic       rise_pol;
    logic       gpio_mode;
  } tif_cfg_t;

  // Kind of edge seen on the filtered level.
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } tif_edge_e;

endpackage

// File: rtl/tif_pin_sync.sv
module tif_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/tif_width_filter.sv
module tif_width_filter #(
  parameter int CODE_W  = 4,
  parameter int MAX_LOG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic              tick,
  input  logic              fast_clk,
  input  logic [CODE_W-1:0] code,
  output logic              level
);

  localparam int CNT_W = MAX_LOG + 1;
  localparam logic [CODE_W-1:0] CODE_SAT = CODE_W'(MAX_LOG);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic [CODE_W-1:0] eff_log;
  logic              bypass;
  logic              count_en;

  // Codes above the largest setting saturate to it.
  always_comb begin
    eff_log  = (code > CODE_SAT) ? CODE_SAT : code;
    limit    = (ONE << eff_log) - ONE;
    bypass   = (code == '0);
    count_en = fast_clk | tick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (bypass) begin
      level <= din;
      cnt   <= '0;
    end else if (din == level) begin
      cnt <= '0;
    end else if (count_en) begin
      if (cnt >= limit) begin
        level <= din;
        cnt   <= '0;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  AST_LEVEL_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> (level == $past(din))); // R3

  AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (code != '0 && !fast_clk && !tick) |=> $stable(level)); // R4

endmodule

// File: rtl/tif_edge_qual.sv
module tif_edge_qual
  import tif_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     level,
  input  tif_cfg_t cfg,
  output logic     event_o
);

  logic      prev;
  tif_edge_e kind;
  logic      qualify;

  always_comb begin
    if (level && !prev)      kind = EDGE_RISE;
    else if (!level && prev) kind = EDGE_FALL;
    else                     kind = EDGE_NONE;

    if (cfg.gpio_mode && cfg.both_edges)
      qualify = 1'b0;
    else if (cfg.both_edges)
      qualify = (kind != EDGE_NONE);
    else if (cfg.rise_pol)
      qualify = (kind == EDGE_RISE);
    else
      qualify = (kind == EDGE_FALL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b0;
      event_o <= 1'b0;
    end else begin
      prev    <= level;
      event_o <= qualify;
    end
  end

  AST_GPIO_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg.gpio_mode) && $past(cfg.both_edges)) |-> !event_o); // R7

endmodule

// File: rtl/tif_flag_unit.sv
module tif_flag_unit #(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            event_i,
  input  logic [TB_W-1:0] timebase_i,
  input  logic            clr_flag_i,
  input  logic            clr_ovr_i,
  input  logic            dma_ack_i,
  input  logic            flag_en,
  input  logic            dma_sel,
  output logic [TB_W-1:0] capture_o,
  output logic            flag_o,
  output logic            ovr_o,
  output logic            irq_o,
  output logic            dma_req_o
);

  logic flag_keep;
  logic flag_nx;
  logic ovr_nx;
  logic any_nx;

  always_comb begin
    flag_keep = flag_o & ~clr_flag_i & ~dma_ack_i;
    flag_nx   = event_i | flag_keep;
    ovr_nx    = (event_i & flag_keep) | (ovr_o & ~clr_ovr_i);
    any_nx    = flag_nx | ovr_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capture_o <= '0;
      flag_o    <= 1'b0;
      ovr_o     <= 1'b0;
      irq_o     <= 1'b0;
      dma_req_o <= 1'b0;
    end else begin
      if (event_i) capture_o <= timebase_i;
      flag_o    <= flag_nx;
      ovr_o     <= ovr_nx;
      irq_o     <= flag_en & ~dma_sel & any_nx;
      dma_req_o <= flag_en &  dma_sel & any_nx;
    end
  end

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !event_i |=> $stable(capture_o)); // R8

  AST_OVR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_o) |-> $past(flag_o)); // R9

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((clr_flag_i || dma_ack_i) && !event_i) |=> !flag_o); // R10

  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_ovr_i && !event_i) |=> !ovr_o); // R10

  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && dma_req_o)); // R11

  AST_ROUTE_GATED: assert property (@(posedge clk) disable iff (rst)
    !flag_en |=> (!irq_o && !dma_req_o)); // R11

endmodule

// File: rtl/tmr_in_filter.sv
module tmr_in_filter
  import tif_pkg::*;
#(
  parameter int TB_W        = 16,
  parameter int CODE_W      = 4,
  parameter int MAX_LOG     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] cfg_width,
  input  logic              cfg_fast_clk,
  input  logic              cfg_both_edges,
  input  logic              cfg_rise_pol,
  input  logic              cfg_gpio_mode,
  input  logic              cfg_flag_en,
  input  logic              cfg_dma_sel,
  input  logic [TB_W-1:0]   timebase_i,
  input  logic              clr_flag_i,
  input  logic              clr_ovr_i,
  input  logic              dma_ack_i,
  output logic              level_o,
  output logic [TB_W-1:0]   capture_o,
  output logic              flag_o,
  output logic              ovr_o,
  output logic              irq_o,
  output logic              dma_req_o
);

  tif_cfg_t cfg;
  logic     pin_s;
  logic     edge_ev;

  always_comb begin
    cfg            = '0;
    cfg.width_code = 4'(cfg_width);
    cfg.fast_clk   = cfg_fast_clk;
    cfg.both_edges = cfg_both_edges;
    cfg.rise_pol   = cfg_rise_pol;
    cfg.gpio_mode  = cfg_gpio_mode;
  end

  tif_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_i),
    .dout (pin_s)
  );

  tif_width_filter #(.CODE_W(CODE_W), .MAX_LOG(MAX_LOG)) u_filt (
    .clk      (clk),
    .rst      (rst),
    .din      (pin_s),
    .tick     (tick_i),
    .fast_clk (cfg_fast_clk),
    .code     (cfg_width),
    .level    (level_o)
  );

  tif_edge_qual u_edge (
    .clk     (clk),
    .rst     (rst),
    .level   (level_o),
    .cfg     (cfg),
    .event_o (edge_ev)
  );

  tif_flag_unit #(.TB_W(TB_W)) u_flag (
    .clk        (clk),
    .rst        (rst),
    .event_i    (edge_ev),
    .timebase_i (timebase_i),
    .clr_flag_i (clr_flag_i),
    .clr_ovr_i  (clr_ovr_i),
    .dma_ack_i  (dma_ack_i),
    .flag_en    (cfg_flag_en),
    .dma_sel    (cfg_dma_sel),
    .capture_o  (capture_o),
    .flag_o     (flag_o),
    .ovr_o      (ovr_o),
    .irq_o      (irq_o),
    .dma_req_o  (dma_req_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!flag_o && !ovr_o && !irq_o && !dma_req_o)); // R1

endmodule

// File: tb/tmr_in_filter_bench.sv
module tmr_in_filter_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_i = 1'b0, tick_i = 1'b0;
  logic [3:0]  cfg_width = 4'd0;
  logic        cfg_fast_clk = 1'b1, cfg_both_edges = 1'b0, cfg_rise_pol = 1'b1;
  logic        cfg_gpio_mode = 1'b0, cfg_flag_en = 1'b0, cfg_dma_sel = 1'b0;
  logic [15:0] timebase_i = 16'h0;
  logic        clr_flag_i = 1'b0, clr_ovr_i = 1'b0, dma_ack_i = 1'b0;
  logic        level_o, flag_o, ovr_o, irq_o, dma_req_o;
  logic [15:0] capture_o;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  int  tdiv   = 0;
  logic [15:0] tbv;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Prescaled strobe: one cycle in four.
  always @(negedge clk) begin
    tdiv   <= (tdiv + 1) % 4;
    tick_i <= (tdiv == 3);
  end

  tmr_in_filter u_tmr_in_filter (
    .clk(clk), .rst(rst), .pin_i(pin_i), .tick_i(tick_i),
    .cfg_width(cfg_width), .cfg_fast_clk(cfg_fast_clk),
    .cfg_both_edges(cfg_both_edges), .cfg_rise_pol(cfg_rise_pol),
    .cfg_gpio_mode(cfg_gpio_mode), .cfg_flag_en(cfg_flag_en),
    .cfg_dma_sel(cfg_dma_sel), .timebase_i(timebase_i),
    .clr_flag_i(clr_flag_i), .clr_ovr_i(clr_ovr_i), .dma_ack_i(dma_ack_i),
    .level_o(level_o), .capture_o(capture_o), .flag_o(flag_o),
    .ovr_o(ovr_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  // Minimum passing pulse width in main-clock cycles (fast filter clock).
  function automatic int min_width(input logic [3:0] code);
    int n;
    n = (code > 4) ? 4 : int'(code);
    return (code == 0) ? 1 : (1 << n);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int w);
    pin_i = 1'b1;
    cyc(w);
    pin_i = 1'b0;
  endtask

  task automatic clear_all;
    clr_flag_i = 1'b1; clr_ovr_i = 1'b1;
    cyc(1);
    clr_flag_i = 1'b0; clr_ovr_i = 1'b0;
    cyc(2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1", "level", level_o, 0);
    chk("R1", "flag", flag_o, 0);
    chk("R1", "ovr", ovr_o, 0);
    chk("R1", "irq|dma", {irq_o, dma_req_o}, 0);
    chk("R1", "capture", capture_o, 0);

    // R2 bypass latency: three rising edges
    cfg_width = 4'd0;
    pin_i = 1'b1;
    cyc(2);
    chk("R2", "level after 2 edges", level_o, 0);
    cyc(1);
    chk("R2", "level after 3 edges", level_o, 1);
    pin_i = 1'b0;
    cyc(10);
    clear_all();

    // R3 saturated code 9 behaves as code 4
    cfg_width = 4'd9;
    pulse(15); cyc(40);
    chk("R3", "code9 width15 flag", flag_o, 0);
    clear_all();
    pulse(16); cyc(40);
    chk("R3", "code9 width16 flag", flag_o, 1);
    clear_all();

    // R3 random widths around each threshold, with captures (R8)
    for (int i = 0; i < 60; i++) begin
      logic [3:0] code;
      int mw, w;
      code = 4'($urandom % 16);
      mw = min_width(code);
      w = mw + int'($urandom % 3) - 1;
      if (w < 1) w = 1;
      cfg_width  = code;
      tbv        = 16'($urandom);
      timebase_i = tbv;
      pulse(w); cyc(40);
      chk("R3", "random pulse flag", flag_o, (w >= mw) ? 1 : 0);
      if (w >= mw) chk("R8", "random capture", capture_o, tbv);
      chk("R3", "level back low", level_o, 0);
      clear_all();
    end

    // R4 prescaled filter clock, code 2 needs 4 strobes
    cfg_fast_clk = 1'b0; cfg_width = 4'd2;
    pulse(6); cyc(60);
    chk("R4", "short pulse blocked", flag_o, 0);
    pulse(24); cyc(60);
    chk("R4", "long pulse passes", flag_o, 1);
    clear_all();
    cfg_fast_clk = 1'b1; cfg_width = 4'd0;

    // R5 falling polarity
    cfg_rise_pol = 1'b0;
    pin_i = 1'b1; cyc(10);
    chk("R5", "rise ignored on fall polarity", flag_o, 0);
    timebase_i = 16'hA55A;
    pin_i = 1'b0; cyc(10);
    chk("R5", "fall flagged", flag_o, 1);
    chk("R8", "capture at fall", capture_o, 16'hA55A);
    clear_all();
    cfg_rise_pol = 1'b1;

    // R6 both edges
    cfg_both_edges = 1'b1;
    pin_i = 1'b1; cyc(10);
    chk("R6", "rise flagged", flag_o, 1);
    clear_all();
    pin_i = 1'b0; cyc(10);
    chk("R6", "fall flagged", flag_o, 1);
    clear_all();

    // R9 overrun: two edges without clearing
    timebase_i = 16'h1111;
    pulse(5); cyc(10);
    chk("R9", "flag", flag_o, 1);
    chk("R9", "overrun", ovr_o, 1);
    clr_ovr_i = 1'b1; cyc(1); clr_ovr_i = 1'b0; cyc(1);
    chk("R10", "ovr cleared, flag kept", {flag_o, ovr_o}, 2'b10);
    clr_flag_i = 1'b1; cyc(1); clr_flag_i = 1'b0; cyc(1);
    chk("R10", "flag cleared", flag_o, 0);

    // R7 GPIO suppression, then GPIO single edge
    cfg_gpio_mode = 1'b1;
    timebase_i = 16'h7E7E;
    pulse(5); cyc(10);
    chk("R7", "gpio suppressed flag", flag_o, 0);
    chk("R7", "gpio suppressed capture", capture_o, 16'h1111);
    cfg_both_edges = 1'b0;
    pulse(5); cyc(10);
    chk("R7", "gpio single-edge flag", flag_o, 1);
    chk("R7", "gpio capture", capture_o, 16'h7E7E);
    cfg_gpio_mode = 1'b0;

    // R10 DMA acknowledge clears flag
    dma_ack_i = 1'b1; cyc(1); dma_ack_i = 1'b0; cyc(1);
    chk("R10", "dma ack clears flag", flag_o, 0);

    // R11 routing
    pulse(5); cyc(10);
    cfg_flag_en = 1'b1; cfg_dma_sel = 1'b0; cyc(2);
    chk("R11", "irq route", {irq_o, dma_req_o}, 2'b10);
    cfg_dma_sel = 1'b1; cyc(2);
    chk("R11", "dma route", {irq_o, dma_req_o}, 2'b01);
    cfg_flag_en = 1'b0; cyc(2);
    chk("R11", "disabled", {irq_o, dma_req_o}, 2'b00);
    clear_all();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule